// File: doc/BRIEF.md
# Protected register unlock sequencer

This block guards a single 8-bit control register so that a stray store cannot change it. Software arms a guard by storing a key byte to a write-only command register. After that, the next three stores in the peripheral address space must all go to the guarded register. They must carry the intended value, then its bitwise inverse, then the intended value again. Only when that triple is complete does the guarded register take the new value. Its contents drive downstream logic through a parallel output port.

Any break in the sequence sets a sticky protection-error flag in a read/write status register, and the guarded register keeps its old contents. A break is a store to another peripheral register, a wrong inverse, or a wrong repeat. The status register also holds two flags set by single-cycle pulses from outside logic: a verify error and a write/erase-protect error. Software clears any flag by writing 0 to its bit. Stores below the peripheral window and all bus reads pass by the sequencer without effect.

Top module: `prot_reg_guard`

## Requirements
- R1: After reset `ctrl_o` is 00h and the status register reads 00h.
- R2: A store of A5h to FFA0h, followed by three peripheral stores to FFA2h carrying V, ~V and V, loads V into `ctrl_o`. The new value shows on the clock edge that takes the third store.
- R3: Once the key has been taken, a peripheral store (address FF00h or above) to any address other than FFA2h sets status bit 0. This includes stores to FFA0h and FFA1h. The sequence is abandoned and `ctrl_o` is unchanged.
- R4: When the second store to FFA2h is not the inverse of the first, or the third differs from the first, status bit 0 is set. The sequence is abandoned and `ctrl_o` is unchanged.
- R5: After a completed or abandoned sequence the sequencer is idle. Stores to FFA2h then neither change `ctrl_o` nor set any flag until A5h is written to FFA0h again.
- R6: Stores to addresses below FF00h and bus reads neither advance nor break a sequence. A store of any value other than A5h to FFA0h while idle is ignored.
- R7: A read (`bus_re_i`) at FFA1h returns the status on `bus_rdata_o`, which changes with the address in the same cycle. Bit 0 is the protection error, bit 1 the verify error and bit 2 the write/erase-protect error. Bits 7..3 read 0. A read at any other address, or no read, returns 00h.
- R8: A store to FFA1h clears each flag whose data bit is 0 and leaves each flag whose data bit is 1 unchanged.
- R9: A pulse on `verify_err_set_i` sets bit 1, and a pulse on `wprot_err_set_i` sets bit 2, on the next edge. Any flag set cause wins over a clear by a status store in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_we_i | input | 1 | Store strobe, one store per cycle |
| bus_re_i | input | 1 | Read strobe |
| bus_addr_i | input | 16 | Bus address |
| bus_wdata_i | input | 8 | Store data |
| bus_rdata_o | output | 8 | Read data, combinational |
| verify_err_set_i | input | 1 | Pulse that sets the verify-error flag |
| wprot_err_set_i | input | 1 | Pulse that sets the write/erase-protect error flag |
| ctrl_o | output | 8 | Guarded register contents |

## Verification
Two pairs of events can fall in the same cycle. In the first, a status store clears a flag while that flag's own set cause fires. In the second, a status store issued in the middle of a sequence both breaks the sequence and tries to clear the protection-error bit it sets. The bench provokes the second pair with a key followed by a store of 00h to FFA1h. It provokes the first with pulses that coincide with zero-writes, both directed and at random. Each outcome is judged against a bench model in which set beats clear, by reading the status back on the next cycle.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int unsigned NFLAG     = 3;
  localparam int unsigned FLAG_PROT = 0;
  localparam int unsigned FLAG_VER  = 1;
  localparam int unsigned FLAG_WPR  = 2;

  typedef enum logic [1:0] {
    SEQ_IDLE     = 2'd0,
    SEQ_ARMED    = 2'd1,
    SEQ_HAVE_VAL = 2'd2,
    SEQ_HAVE_INV = 2'd3
  } seq_e;
endpackage

// File: rtl/prg_bus_decode.sv
module prg_bus_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 16'hFF00,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 16'hFFA0,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 16'hFFA1,
  parameter logic [ADDR_W-1:0] PROT_ADDR   = 16'hFFA2
) (
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              per_wr_o,
  output logic              cmd_wr_o,
  output logic              stat_wr_o,
  output logic              prot_wr_o,
  output logic              stat_rd_o
);
  logic in_window;

  assign in_window = (addr_i >= PERIPH_BASE);
  assign per_wr_o  = we_i && in_window;
  assign cmd_wr_o  = per_wr_o && (addr_i == CMD_ADDR);
  assign stat_wr_o = per_wr_o && (addr_i == STAT_ADDR);
  assign prot_wr_o = per_wr_o && (addr_i == PROT_ADDR);
  assign stat_rd_o = re_i && (addr_i == STAT_ADDR);
endmodule

// File: rtl/prg_unlock_fsm.sv
module prg_unlock_fsm
  import prg_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter logic [DATA_W-1:0] KEY = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              per_wr_i,
  input  logic              cmd_wr_i,
  input  logic              prot_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              commit_o,
  output logic [DATA_W-1:0] commit_data_o,
  output logic              err_o,
  output logic              busy_o
);
  seq_e              st_q, st_d;
  logic [DATA_W-1:0] val_q, val_d;

  always_comb begin
    st_d     = st_q;
    val_d    = val_q;
    commit_o = 1'b0;
    err_o    = 1'b0;
    if (per_wr_i) begin
      case (st_q)
        SEQ_IDLE: begin
          if (cmd_wr_i && (wdata_i == KEY)) st_d = SEQ_ARMED;
        end
        SEQ_ARMED: begin
          if (prot_wr_i) begin
            val_d = wdata_i;
            st_d  = SEQ_HAVE_VAL;
          end else begin
            err_o = 1'b1;
            st_d  = SEQ_IDLE;
          end
        end
        SEQ_HAVE_VAL: begin
          if (prot_wr_i && (wdata_i == ~val_q)) begin
            st_d = SEQ_HAVE_INV;
          end else begin
            err_o = 1'b1;
            st_d  = SEQ_IDLE;
          end
        end
        SEQ_HAVE_INV: begin
          if (prot_wr_i && (wdata_i == val_q)) commit_o = 1'b1;
          else err_o = 1'b1;
          st_d = SEQ_IDLE;
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SEQ_IDLE;
      val_q <= '0;
    end else begin
      st_q  <= st_d;
      val_q <= val_d;
    end
  end

  assign commit_data_o = val_q;
  assign busy_o        = (st_q != SEQ_IDLE);
endmodule

// File: rtl/prg_status_reg.sv
module prg_status_reg
  import prg_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stat_wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [NFLAG-1:0]  set_i,
  output logic [NFLAG-1:0]  flags_o
);
  for (genvar g = 0; g < NFLAG; g++) begin : g_flag
    logic q;
    logic clr;
    assign clr = stat_wr_i && !wdata_i[g];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (set_i[g]) q <= 1'b1;  // set beats clear
      else if (clr)      q <= 1'b0;
    end
    assign flags_o[g] = q;
  end
endmodule

// File: rtl/prot_reg_guard.sv
module prot_reg_guard
  import prg_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 16'hFF00,
  parameter logic [ADDR_W-1:0] CMD_ADDR    = 16'hFFA0,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 16'hFFA1,
  parameter logic [ADDR_W-1:0] PROT_ADDR   = 16'hFFA2,
  parameter logic [DATA_W-1:0] KEY         = 8'hA5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic              bus_re_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              verify_err_set_i,
  input  logic              wprot_err_set_i,
  output logic [DATA_W-1:0] ctrl_o
);
  localparam int unsigned PAD_W = DATA_W - NFLAG;

  logic              per_wr, cmd_wr, stat_wr, prot_wr, stat_rd;
  logic              commit, seq_err, seq_busy;
  logic [DATA_W-1:0] commit_data;
  logic [NFLAG-1:0]  flag_set, stat_q;
  logic [DATA_W-1:0] ctrl_q;

  prg_bus_decode #(
    .ADDR_W(ADDR_W), .PERIPH_BASE(PERIPH_BASE), .CMD_ADDR(CMD_ADDR),
    .STAT_ADDR(STAT_ADDR), .PROT_ADDR(PROT_ADDR)
  ) u_dec (
    .we_i(bus_we_i), .re_i(bus_re_i), .addr_i(bus_addr_i),
    .per_wr_o(per_wr), .cmd_wr_o(cmd_wr), .stat_wr_o(stat_wr),
    .prot_wr_o(prot_wr), .stat_rd_o(stat_rd)
  );

  prg_unlock_fsm #(.DATA_W(DATA_W), .KEY(KEY)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .per_wr_i(per_wr), .cmd_wr_i(cmd_wr), .prot_wr_i(prot_wr),
    .wdata_i(bus_wdata_i),
    .commit_o(commit), .commit_data_o(commit_data),
    .err_o(seq_err), .busy_o(seq_busy)
  );

  always_comb begin
    flag_set            = '0;
    flag_set[FLAG_PROT] = seq_err;
    flag_set[FLAG_VER]  = verify_err_set_i;
    flag_set[FLAG_WPR]  = wprot_err_set_i;
  end

  prg_status_reg #(.DATA_W(DATA_W)) u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .stat_wr_i(stat_wr), .wdata_i(bus_wdata_i),
    .set_i(flag_set), .flags_o(stat_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ctrl_q <= '0;
    else if (commit) ctrl_q <= commit_data;
  end

  assign ctrl_o      = ctrl_q;
  assign bus_rdata_o = stat_rd ? {{PAD_W{1'b0}}, stat_q} : '0;
endmodule

// File: rtl/prg_guard_chk.sv
module prg_guard_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter logic [ADDR_W-1:0] PERIPH_BASE = 16'hFF00,
  parameter logic [ADDR_W-1:0] STAT_ADDR   = 16'hFFA1,
  parameter logic [ADDR_W-1:0] PROT_ADDR   = 16'hFFA2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_we_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_wdata_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic              verify_err_set_i,
  input logic              wprot_err_set_i,
  input logic [DATA_W-1:0] ctrl_o,
  input logic [2:0]        stat_i,
  input logic              busy_i
);
  assert_ctrl_only_by_prot_store_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_o) |-> $past(bus_we_i && (bus_addr_i == PROT_ADDR)));

  assert_break_sets_prot_err_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && bus_we_i && (bus_addr_i >= PERIPH_BASE) && (bus_addr_i != PROT_ADDR))
    |=> stat_i[0]);

  assert_upper_status_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_rdata_o[DATA_W-1:3] == '0);

  assert_prot_clear_by_zero_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(stat_i[0]) |-> $past(bus_we_i && (bus_addr_i == STAT_ADDR) && !bus_wdata_i[0]));

  assert_verify_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    verify_err_set_i |=> stat_i[1]);

  assert_wprot_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wprot_err_set_i |=> stat_i[2]);
endmodule

bind prot_reg_guard prg_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PERIPH_BASE(PERIPH_BASE),
  .STAT_ADDR(STAT_ADDR), .PROT_ADDR(PROT_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
  .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
  .verify_err_set_i(verify_err_set_i), .wprot_err_set_i(wprot_err_set_i),
  .ctrl_o(ctrl_o), .stat_i(stat_q), .busy_i(seq_busy)
);

// File: tb/tb_prot_reg_guard.sv
`timescale 1ns/100ps
module tb_prot_reg_guard;
  localparam logic [15:0] A_CMD  = 16'hFFA0;
  localparam logic [15:0] A_STAT = 16'hFFA1;
  localparam logic [15:0] A_PROT = 16'hFFA2;
  localparam logic [15:0] A_OTH  = 16'hFF10;
  localparam logic [15:0] A_LOW  = 16'h1234;

  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0, vs = 1'b0, ws = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0] wd = '0, rdata, ctrl;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // bench reference
  int m_st = 0;
  logic [7:0] m_val = '0, m_ctrl = '0;
  logic [2:0] m_stat = '0;

  always #2.5 clk = ~clk;

  prot_reg_guard dut (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_re_i(re),
    .bus_addr_i(addr), .bus_wdata_i(wd), .bus_rdata_o(rdata),
    .verify_err_set_i(vs), .wprot_err_set_i(ws), .ctrl_o(ctrl)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit perr = 0;
    if (we && addr >= 16'hFF00) begin
      case (m_st)
        0: if (addr == A_CMD && wd == 8'hA5) m_st = 1;
        1: if (addr == A_PROT) begin m_val = wd; m_st = 2; end
           else begin perr = 1; m_st = 0; end
        2: if (addr == A_PROT && wd == ~m_val) m_st = 3;
           else begin perr = 1; m_st = 0; end
        default: begin
          if (addr == A_PROT && wd == m_val) m_ctrl = m_val;
          else perr = 1;
          m_st = 0;
        end
      endcase
    end
    for (int i = 0; i < 3; i++) begin
      bit st_clr = we && addr == A_STAT && !wd[i];
      bit st_set = (i == 0) ? perr : (i == 1) ? vs : ws;
      if (st_set) m_stat[i] = 1'b1;
      else if (st_clr) m_stat[i] = 1'b0;
    end
  endtask

  task automatic cyc(input logic w, input logic r, input logic [15:0] a,
                     input logic [7:0] d, input logic v, input logic p, input string tag);
    @(negedge clk);
    we = w; re = r; addr = a; wd = d; vs = v; ws = p;
    #1;
    chk({tag, " rdata"}, rdata, (r && a == A_STAT) ? {5'b0, m_stat} : 8'h00);
    @(posedge clk);
    #1;
    model_step();
    chk({tag, " ctrl"}, ctrl, m_ctrl);
    we = 0; re = 0; vs = 0; ws = 0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
    cyc(1, 0, a, d, 0, 0, tag);
  endtask

  task automatic rd_stat(input string tag);
    cyc(0, 1, A_STAT, 8'h00, 0, 0, tag);
  endtask

  // mode 0 good, 1 bad inverse, 2 bad repeat, 3 foreign store after key
  task automatic seq(input logic [7:0] v, input int mode, input string tag);
    wr(A_CMD, 8'hA5, tag);
    if (mode == 3) begin wr(A_OTH, v, tag); return; end
    wr(A_PROT, v, tag);
    wr(A_PROT, (mode == 1) ? ~v ^ 8'h01 : ~v, tag);
    wr(A_PROT, (mode == 2) ? v ^ 8'h80 : v, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unsigned seed_r;
    seed_r = $urandom(32'd7719);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 ctrl reset", ctrl, 8'h00);
    rd_stat("R1");

    seq(8'h3C, 0, "R2");
    chk("R2 commit", ctrl, 8'h3C);
    rd_stat("R2");

    // low-address stores and reads inside sequence
    wr(A_CMD, 8'hA5, "R6");
    cyc(1, 0, A_LOW, 8'h11, 0, 0, "R6");
    wr(A_PROT, 8'h5A, "R6");
    cyc(0, 1, A_OTH, 8'h00, 0, 0, "R6 R7");
    wr(A_PROT, 8'hA5, "R6");
    cyc(1, 0, 16'h00A2, 8'h00, 0, 0, "R6");
    wr(A_PROT, 8'h5A, "R6");
    chk("R6 commit", ctrl, 8'h5A);
    rd_stat("R6");

    // non-key command then triple: ignored
    wr(A_CMD, 8'h5A, "R6");
    wr(A_PROT, 8'h77, "R5"); wr(A_PROT, 8'h88, "R5"); wr(A_PROT, 8'h77, "R5");
    chk("R5 no commit", ctrl, 8'h5A);
    rd_stat("R5");

    seq(8'h42, 3, "R3");
    chk("R3 ctrl kept", ctrl, 8'h5A);
    rd_stat("R3");
    wr(A_STAT, 8'hFF, "R8");
    rd_stat("R8 write one");
    wr(A_STAT, 8'hFE, "R8");
    rd_stat("R8 write zero");

    seq(8'h99, 1, "R4");
    rd_stat("R4 inverse");
    wr(A_STAT, 8'h00, "R8");
    seq(8'h99, 2, "R4");
    chk("R4 ctrl kept", ctrl, 8'h5A);
    rd_stat("R4 repeat");

    // key then command store breaks too
    wr(A_STAT, 8'h00, "R8");
    wr(A_CMD, 8'hA5, "R3"); wr(A_CMD, 8'hA5, "R3");
    rd_stat("R3 cmd break");
    wr(A_PROT, 8'h01, "R5"); wr(A_PROT, 8'hFE, "R5"); wr(A_PROT, 8'h01, "R5");
    chk("R5 idle after err", ctrl, 8'h5A);

    // status store as the break: set beats clear
    wr(A_STAT, 8'h00, "R8");
    cyc(0, 0, A_LOW, 8'h00, 1, 1, "R9");
    rd_stat("R9 pulses");
    wr(A_CMD, 8'hA5, "R9");
    wr(A_STAT, 8'h00, "R9");
    rd_stat("R9 break vs clear");
    cyc(1, 0, A_STAT, 8'h00, 1, 0, "R9");
    rd_stat("R9 pulse vs clear");
    cyc(1, 0, A_STAT, 8'h00, 0, 0, "R8");
    rd_stat("R8 all clear");

    for (int it = 0; it < 3000; it++) begin
      int unsigned k = $urandom_range(0, 9);
      if (k < 3) seq(8'($urandom), (k == 0) ? 0 : $urandom_range(0, 3), "R2 R4 rnd");
      else begin
        logic [15:0] a;
        int unsigned s = $urandom_range(0, 4);
        a = (s == 0) ? A_CMD : (s == 1) ? A_STAT : (s == 2) ? A_PROT :
            (s == 3) ? A_OTH : A_LOW;
        cyc(1'($urandom), 1'($urandom), a,
            ($urandom_range(0, 3) == 0) ? 8'hA5 : 8'($urandom),
            ($urandom_range(0, 7) == 0), ($urandom_range(0, 7) == 0), "R3 R8 R9 rnd");
      end
    end
    rd_stat("R7 final");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule